// File: doc/BRIEF.md
# Per-Destination Input Queue with Out-of-Order Removal

This block is the receive-side packet buffer for one input of a four-output switch. Each arriving packet descriptor carries an 8-bit destination address and a small tag. A writable routing table turns the address into one of four output ports. The block holds up to eight descriptors. Each one is stamped with the value of a free-running local counter at the moment it is accepted.

The buffer does not show a single head entry. It shows four views at once, one per output port. Each view presents the earliest-accepted descriptor still waiting for that port, together with its stamp. An arbiter downstream grants one or more ports. Each granted view's descriptor leaves the buffer from wherever it sits, so a later packet for an idle port never waits behind an older packet for a busy one. The occupancy is always visible.

Top module: `mvq_input_queue`

## Requirements
- R1: While reset is asserted and on the first cycle after it, occupancy is 0, in_ready is 1 and all four view_valid bits are 0. Every routing table entry resets to port 0.
- R2: When in_valid and in_ready are both high at a clock edge, the descriptor is stored and occupancy rises by one after that edge, provided no removal happens in the same cycle.
- R3: occupancy never exceeds 8. in_ready is low exactly when occupancy is 8. A descriptor offered while in_ready is low is dropped and leaves occupancy unchanged.
- R4: A stored descriptor's destination port is routing table entry in_addr, taken as it stood before the accepting edge. When cfg_we is high, entry cfg_addr takes the value cfg_port at the clock edge, and later insertions use the new value.
- R5: The local stamp is 16 bits wide. It is 0 on the first edge out of reset, rises by one on every clock and wraps. A descriptor keeps the stamp value that was current at its accepting edge.
- R6: For each port p, view_valid[p] is high when any stored descriptor is routed to p. view_tag[p*8 +: 8] and view_stamp[p*16 +: 16] then show the earliest-accepted such descriptor.
- R7: A grant[p] that is high at a clock edge while view_valid[p] is high removes the descriptor shown on view p, whatever its position in arrival order. Up to four ports may be granted in one cycle.
- R8: A grant[p] raised while view_valid[p] is low has no effect.
- R9: An insertion and one or more removals in the same cycle are all carried out. The new occupancy is the old one plus one minus the number of removals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Buffer can take a descriptor |
| in_addr | input | 8 | Destination address of offered descriptor |
| in_tag | input | 8 | Tag of offered descriptor |
| cfg_we | input | 1 | Routing table write enable |
| cfg_addr | input | 8 | Routing table entry to write |
| cfg_port | input | 2 | Output port stored in that entry |
| grant | input | 4 | Per-port removal of the viewed descriptor |
| view_valid | output | 4 | Per-port view present |
| view_tag | output | 32 | Per-port tag, port p at bits p*8 +: 8 |
| view_stamp | output | 64 | Per-port stamp, port p at bits p*16 +: 16 |
| occupancy | output | 4 | Number of stored descriptors |

## Verification
The case that needs care is an insertion and a removal landing on the same edge. The new descriptor must go into a free slot and be ordered after every survivor, and the count must move by the net amount. The bench sets this up directly at an occupancy of seven. It offers a packet for port 3 while granting the only older port-3 entry. It then expects the occupancy to stay at seven and view 3 to show the new tag. A long random phase mixes offers, multi-port grants and table writes on the same cycles. A behavioural queue model is compared against every view, the occupancy and in_ready after each edge.

// File: rtl/mvq_pkg.sv
package mvq_pkg;

  // Population count over a 32-bit vector; callers zero-extend narrower masks.
  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'd0, v[i]};
    return n;
  endfunction

  // Index of the lowest clear bit among the first n bits (n when none).
  function automatic int unsigned lowest_clear(input logic [31:0] v, input int unsigned n);
    int unsigned k;
    k = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && !v[i]) k = i;
    end
    return k;
  endfunction

endpackage

// File: rtl/mvq_route_table.sv
module mvq_route_table #(
  parameter int ADDR_W = 8,
  parameter int PW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [PW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rdata
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [ENTRIES-1:0][PW-1:0] map_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (we) begin
      map_q[waddr] <= wdata;
    end
  end

  // Asynchronous read: an insertion sees the table as it stood before the edge.
  assign rdata = map_q[raddr];

endmodule

// File: rtl/mvq_slot_store.sv
module mvq_slot_store #(
  parameter int DEPTH   = 8,
  parameter int TAG_W   = 8,
  parameter int STAMP_W = 16,
  parameter int PW      = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ins_en,
  input  logic [TAG_W-1:0]                  ins_tag,
  input  logic [PW-1:0]                     ins_dest,
  input  logic [STAMP_W-1:0]                ins_stamp,
  input  logic [DEPTH-1:0]                  rm_mask,
  output logic [DEPTH-1:0]                  valid_q,
  output logic [DEPTH-1:0][TAG_W-1:0]       tag_q,
  output logic [DEPTH-1:0][PW-1:0]          dest_q,
  output logic [DEPTH-1:0][STAMP_W-1:0]     stamp_q,
  output logic [DEPTH-1:0][DEPTH-1:0]       older_q
);
  import mvq_pkg::*;

  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // older_q[j][i] set: slot j was accepted before slot i
  logic [SW-1:0] free_slot;

  always_comb begin
    free_slot = SW'(lowest_clear(32'(valid_q), DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      dest_q  <= '0;
      stamp_q <= '0;
      older_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rm_mask[i]) valid_q[i] <= 1'b0;
      end
      if (ins_en) begin
        valid_q[free_slot] <= 1'b1;
        tag_q[free_slot]   <= ins_tag;
        dest_q[free_slot]  <= ins_dest;
        stamp_q[free_slot] <= ins_stamp;
        for (int j = 0; j < DEPTH; j++) begin
          older_q[free_slot][j] <= 1'b0;
          older_q[j][free_slot] <= valid_q[j] && !rm_mask[j];
        end
      end
    end
  end

endmodule

// File: rtl/mvq_oldest_pick.sv
module mvq_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int PW    = 2,
  parameter int PORT  = 0
) (
  input  logic [DEPTH-1:0]             valid_q,
  input  logic [DEPTH-1:0][PW-1:0]     dest_q,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older_q,
  output logic [DEPTH-1:0]             sel,
  output logic                         any
);
  logic [DEPTH-1:0] cand;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cand[i] = valid_q[i] && (dest_q[i] == PW'(PORT));
    end
  end

  // A candidate wins when no other candidate is older than it.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (cand[j] && older_q[j][i]) beaten = 1'b1;
      end
      sel[i] = cand[i] && !beaten;
    end
  end

  assign any = |cand;

endmodule

// File: rtl/mvq_input_queue.sv
module mvq_input_queue #(
  parameter int DEPTH   = 8,
  parameter int NPORT   = 4,
  parameter int ADDR_W  = 8,
  parameter int TAG_W   = 8,
  parameter int STAMP_W = 16,
  localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic [TAG_W-1:0]          in_tag,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [PW-1:0]             cfg_port,
  input  logic [NPORT-1:0]          grant,
  output logic [NPORT-1:0]          view_valid,
  output logic [NPORT*TAG_W-1:0]    view_tag,
  output logic [NPORT*STAMP_W-1:0]  view_stamp,
  output logic [CW-1:0]             occupancy
);
  import mvq_pkg::*;

  // Named internal events, used by the bound checker
  logic                          accept;
  logic [DEPTH-1:0]              rm_mask;
  logic [CW-1:0]                 rm_count;
  logic [STAMP_W-1:0]            stamp_now;
  logic [NPORT-1:0][DEPTH-1:0]   port_sel;
  logic [DEPTH-1:0]              slot_valid;

  logic [PW-1:0]                 route_dest;
  logic [DEPTH-1:0][TAG_W-1:0]   tag_q;
  logic [DEPTH-1:0][PW-1:0]      dest_q;
  logic [DEPTH-1:0][STAMP_W-1:0] stamp_q;
  logic [DEPTH-1:0][DEPTH-1:0]   older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_now <= '0;
    else        stamp_now <= stamp_now + 1'b1;
  end

  assign occupancy = CW'(count_ones(32'(slot_valid)));
  assign in_ready  = (occupancy < CW'(DEPTH));
  assign accept    = in_valid && in_ready;

  mvq_route_table #(.ADDR_W(ADDR_W), .PW(PW)) u_route (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_port),
    .raddr (in_addr),
    .rdata (route_dest)
  );

  mvq_slot_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .STAMP_W(STAMP_W), .PW(PW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_en    (accept),
    .ins_tag   (in_tag),
    .ins_dest  (route_dest),
    .ins_stamp (stamp_now),
    .rm_mask   (rm_mask),
    .valid_q   (slot_valid),
    .tag_q     (tag_q),
    .dest_q    (dest_q),
    .stamp_q   (stamp_q),
    .older_q   (older_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_view
    mvq_oldest_pick #(.DEPTH(DEPTH), .PW(PW), .PORT(p)) u_pick (
      .valid_q (slot_valid),
      .dest_q  (dest_q),
      .older_q (older_q),
      .sel     (port_sel[p]),
      .any     (view_valid[p])
    );

    always_comb begin
      view_tag[p*TAG_W +: TAG_W]       = '0;
      view_stamp[p*STAMP_W +: STAMP_W] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (port_sel[p][i]) begin
          view_tag[p*TAG_W +: TAG_W]       = view_tag[p*TAG_W +: TAG_W] | tag_q[i];
          view_stamp[p*STAMP_W +: STAMP_W] = view_stamp[p*STAMP_W +: STAMP_W] | stamp_q[i];
        end
      end
    end
  end

  always_comb begin
    rm_mask = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (grant[p]) rm_mask = rm_mask | port_sel[p];
    end
  end

  assign rm_count = CW'(count_ones(32'(rm_mask)));

endmodule

// File: rtl/mvq_checker.sv
module mvq_checker #(
  parameter int DEPTH   = 8,
  parameter int NPORT   = 4,
  parameter int STAMP_W = 16,
  parameter int CW      = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_ready,
  input logic                        accept,
  input logic [CW-1:0]               occupancy,
  input logic [CW-1:0]               rm_count,
  input logic [DEPTH-1:0]            rm_mask,
  input logic [DEPTH-1:0]            slot_valid,
  input logic [STAMP_W-1:0]          stamp_now,
  input logic [NPORT-1:0][DEPTH-1:0] port_sel
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH));

  a_r3_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CW'(DEPTH)) |-> !in_ready);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occupancy == CW'($past(occupancy) + CW'($past(accept)) - $past(rm_count)));

  a_r5_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stamp_now == STAMP_W'($past(stamp_now) + 1'b1));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    a_r7_removed_gone: assert property (@(posedge clk) disable iff (!rst_n)
      rm_mask[i] |=> !slot_valid[i]);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_sel[p]));
  end

endmodule

bind mvq_input_queue mvq_checker #(
  .DEPTH(DEPTH), .NPORT(NPORT), .STAMP_W(STAMP_W), .CW(CW)
) u_mvq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .accept     (accept),
  .occupancy  (occupancy),
  .rm_count   (rm_count),
  .rm_mask    (rm_mask),
  .slot_valid (slot_valid),
  .stamp_now  (stamp_now),
  .port_sel   (port_sel)
);

// File: tb/mvq_input_queue_bench.sv
module mvq_input_queue_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_addr = '0;
  logic [7:0]  in_tag = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [1:0]  cfg_port = '0;
  logic [3:0]  grant = '0;
  logic [3:0]  view_valid;
  logic [31:0] view_tag;
  logic [63:0] view_stamp;
  logic [3:0]  occupancy;

  always #2 clk = ~clk;

  mvq_input_queue u_mvq_input_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_tag(in_tag), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_port(cfg_port), .grant(grant), .view_valid(view_valid),
    .view_tag(view_tag), .view_stamp(view_stamp), .occupancy(occupancy)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: arrival-ordered list of descriptors
  typedef struct { int tag; int dest; int stamp; } ent_t;
  ent_t mq[$];
  int   rtab[256];
  int   m_stamp = 0;
  bit   both_last = 0;

  always @(posedge clk) begin
    int   first[4];
    ent_t nq[$];
    bit   acc;
    int   nd;
    int   removed;
    if (!rst_n) begin
      mq.delete();
      m_stamp = 0;
      for (int a = 0; a < 256; a++) rtab[a] = 0;
      both_last = 0;
    end else begin
      for (int p = 0; p < 4; p++) first[p] = -1;
      for (int i = mq.size() - 1; i >= 0; i--) first[mq[i].dest] = i;
      acc = in_valid && (mq.size() < 8);
      nd = rtab[in_addr];
      removed = 0;
      nq.delete();
      for (int i = 0; i < mq.size(); i++) begin
        bit gone;
        gone = 0;
        for (int p = 0; p < 4; p++) if (grant[p] && first[p] == i) gone = 1;
        if (gone) removed++;
        else nq.push_back(mq[i]);
      end
      if (acc) nq.push_back('{tag: int'(in_tag), dest: nd, stamp: m_stamp});
      mq = nq;
      if (cfg_we) rtab[cfg_addr] = int'(cfg_port);
      m_stamp = (m_stamp + 1) % 65536;
      both_last = acc && (removed > 0);
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(occupancy == 4'(mq.size()), both_last ? "R9" : "R2", "occupancy",
          int'(occupancy), mq.size());
      chk(in_ready == (mq.size() < 8), "R3", "in_ready", int'(in_ready), int'(mq.size() < 8));
      for (int p = 0; p < 4; p++) begin
        int idx;
        idx = -1;
        for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].dest == p) idx = i;
        chk(view_valid[p] == (idx >= 0), "R6", "view_valid", int'(view_valid[p]), int'(idx >= 0));
        if (idx >= 0) begin
          chk(int'(view_tag[p*8 +: 8]) == mq[idx].tag, "R6", "view_tag",
              int'(view_tag[p*8 +: 8]), mq[idx].tag);
          chk(int'(view_stamp[p*16 +: 16]) == mq[idx].stamp, "R5", "view_stamp",
              int'(view_stamp[p*16 +: 16]), mq[idx].stamp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; grant = '0; cfg_we = 0;
  endtask

  task automatic push(input int addr, input int tag);
    in_valid = 1; in_addr = 8'(addr); in_tag = 8'(tag);
    cyc();
  endtask

  task automatic cfg(input int addr, input int port);
    cfg_we = 1; cfg_addr = 8'(addr); cfg_port = 2'(port);
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk(occupancy == 0, "R1", "occupancy in reset", int'(occupancy), 0);
    chk(in_ready == 1, "R1", "in_ready in reset", int'(in_ready), 1);
    chk(view_valid == 0, "R1", "view_valid in reset", int'(view_valid), 0);
    rst_n = 1;
    cyc();
    chk(occupancy == 0 && view_valid == 0, "R1", "empty after reset", int'(occupancy), 0);

    // R1: unwritten address routes to port 0
    push(99, 8'h01);
    chk(view_valid == 4'b0001, "R1", "default route", int'(view_valid), 1);
    grant = 4'b0001; cyc();

    // R4: table writes steer later insertions
    cfg(10, 2); cfg(20, 1); cfg(30, 3);
    push(10, 8'h11);
    chk(view_valid == 4'b0100, "R4", "routed view", int'(view_valid), 4);
    chk(view_tag[23:16] == 8'h11, "R4", "routed tag", int'(view_tag[23:16]), 'h11);

    // R4: write and insert on the same edge use the old entry
    cfg_we = 1; cfg_addr = 8'd40; cfg_port = 2'd1;
    in_valid = 1; in_addr = 8'd40; in_tag = 8'h66;
    cyc();
    chk(view_valid[0] == 1 && view_tag[7:0] == 8'h66, "R4", "old table used",
        int'(view_tag[7:0]), 'h66);
    grant = 4'b0001; cyc();

    // R5: back-to-back stamps differ by one
    push(30, 8'h22);
    s0 = int'(view_stamp[63:48]);
    push(10, 8'h33);
    push(10, 8'h44);
    grant = 4'b0100; cyc();
    chk(view_tag[23:16] == 8'h33, "R7", "head removed", int'(view_tag[23:16]), 'h33);
    chk(int'(view_stamp[47:32]) == (s0 + 1) % 65536, "R5", "stamp step",
        int'(view_stamp[47:32]), (s0 + 1) % 65536);

    // R7: remove an entry that is not the oldest overall
    grant = 4'b0100; cyc();
    chk(view_tag[23:16] == 8'h44 && occupancy == 2, "R7", "middle removal",
        int'(view_tag[23:16]), 'h44);

    // R8: grant on an empty view
    grant = 4'b0010; cyc();
    chk(occupancy == 2, "R8", "idle grant count", int'(occupancy), 2);
    chk(view_tag[31:24] == 8'h22 && view_tag[23:16] == 8'h44, "R8", "idle grant views",
        int'(view_tag[31:24]), 'h22);

    // R3: fill, then refuse
    for (int k = 0; k < 6; k++) push(0, 8'h80 + k);
    chk(occupancy == 8 && in_ready == 0, "R3", "full", int'(occupancy), 8);
    push(0, 8'hEE);
    chk(occupancy == 8, "R3", "refused while full", int'(occupancy), 8);
    in_valid = 1; in_addr = 8'd0; in_tag = 8'hEF; grant = 4'b0001; cyc();
    chk(occupancy == 7 && view_tag[7:0] == 8'h81, "R3", "full grant+offer",
        int'(view_tag[7:0]), 'h81);

    // R9: insert and remove on one edge
    in_valid = 1; in_addr = 8'd30; in_tag = 8'h55; grant = 4'b1000; cyc();
    chk(occupancy == 7, "R9", "net occupancy", int'(occupancy), 7);
    chk(view_tag[31:24] == 8'h55, "R9", "new entry viewed", int'(view_tag[31:24]), 'h55);

    // Mixed random traffic (all requirements via the model)
    for (int c = 0; c < 4000; c++) begin
      in_valid = ($urandom % 10) < 6;
      in_addr = 8'($urandom % 48);
      in_tag = 8'($urandom);
      for (int p = 0; p < 4; p++) grant[p] = ($urandom % 10) < 3;
      if (($urandom % 20) == 0) begin
        cfg_we = 1; cfg_addr = 8'($urandom % 48); cfg_port = 2'($urandom);
      end
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule